// File: doc/BRIEF.md
# Serial Audio Clock Master Generator

This block sits next to a stereo serial audio data serializer and, when the chip is the clock master, produces the frame clock (left/right select) and the bit clock from the master clock. The two clock pins are shared with configuration straps. For a fixed window after reset the pins are left undriven, and the levels seen on them are read as straps. When the window closes, the block starts driving them as clocks.

The frame-clock strap picks normal or double rate. The bit-clock strap picks a base master-clock-to-frame ratio of 256x or 384x. A divide-enable input doubles the resulting ratio. Every frame holds 64 bit-clock periods, so one bit-clock period lasts ratio/64 master-clock cycles. That gives 2, 3, 4, 6, 8 or 12 cycles for the supported ratios 128x, 192x, 256x, 384x, 512x and 768x. The block also gives the serializer a one-cycle bit strobe and a one-cycle frame strobe. When the mode-select input is low at the end of the window, the block stays silent and never drives the pins.

Top module: `aud_clk_master`

## Requirements
- R1: If `master_sel` is low on the last cycle of the strap window, `lr_oe` and `bc_oe` stay 0 and `lr_clk`, `bc_clk`, `bit_stb` and `frame_stb` stay 0 until the next reset.
- R2: After `rst_n` rises, both output enables stay 0 for STRAP_CYCLES (default 1024) clock edges. The straps, `div_en` and `master_sel` are sampled on the STRAP_CYCLES-th edge, and both enables read 1 together right after it.
- R3: The bit-clock period P, in master-clock cycles, is set as follows. `lr_strap`=0,`bc_strap`=0 gives 4. `lr_strap`=0,`bc_strap`=1 gives 6. `lr_strap`=1,`bc_strap`=0 gives 2. `lr_strap`=1,`bc_strap`=1 gives 3. P is doubled when `div_en`=1.
- R4: `bc_clk` starts low on the first enabled cycle. In each period it is low for P-floor(P/2) cycles and then high for floor(P/2) cycles.
- R5: `lr_clk` is 0 (left word) for 32 bit-clock periods and then 1 (right word) for 32, starting low on the first enabled cycle. It changes only in a cycle where `bc_clk` falls.
- R6: `bit_stb` is 1 for exactly the first cycle of each bit-clock period, which is the cycle `bc_clk` goes low. This includes the first enabled cycle.
- R7: `frame_stb` is 1 for exactly one cycle at each `lr_clk` edge, and also on the first enabled cycle.
- R8: Once the window has closed, changes on `lr_strap`, `bc_strap`, `div_en` and `master_sel` have no effect until the next reset.
- R9: While `rst_n` is low, all outputs are 0. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_sel | input | 1 | 1 selects clock master, 0 selects slave |
| lr_strap | input | 1 | Level seen on the frame-clock pin; 1 selects double rate |
| bc_strap | input | 1 | Level seen on the bit-clock pin; 1 selects a 384x base ratio |
| div_en | input | 1 | 1 doubles the ratio |
| lr_clk | output | 1 | Frame clock; 0 means left word |
| bc_clk | output | 1 | Bit clock |
| lr_oe | output | 1 | Drive enable for the frame-clock pin |
| bc_oe | output | 1 | Drive enable for the bit-clock pin |
| bit_stb | output | 1 | One-cycle pulse at each bit-clock falling edge |
| frame_stb | output | 1 | One-cycle pulse at each frame-clock edge |

## Verification
The assertions take for granted that reset is applied before the first check. They also assume the master clock is the only clock, so strap and mode inputs are treated as levels already synchronous to it. The stimulus changes every input at the falling master-clock edge and holds the straps steady through the sampling edge. After enable, it flips every configuration input, which shows that the outputs keep the pattern latched at the window's end.

// File: rtl/aud_clk_master.sv
module aud_clk_master #(
  parameter int STRAP_CYCLES = 1024,
  parameter int FRAME_BITS   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_sel,
  input  logic lr_strap,
  input  logic bc_strap,
  input  logic div_en,
  output logic lr_clk,
  output logic bc_clk,
  output logic lr_oe,
  output logic bc_oe,
  output logic bit_stb,
  output logic frame_stb
);
  localparam int WW = $clog2(STRAP_CYCLES);
  localparam int FW = $clog2(FRAME_BITS);

  logic [WW-1:0] wcnt;
  logic          done, run;
  logic [3:0]    per, cnt, cnt_n, lo, per_sel;
  logic [FW-1:0] bitc, bitc_n;
  logic          wrap;

  assign per_sel = (lr_strap ? (bc_strap ? 4'd3 : 4'd2)
                             : (bc_strap ? 4'd6 : 4'd4)) << div_en;
  assign lo      = per - (per >> 1);
  assign wrap    = (cnt == per - 4'd1);
  assign cnt_n   = wrap ? 4'd0 : cnt + 4'd1;
  assign bitc_n  = wrap ? bitc + 1'b1 : bitc;
  assign lr_oe   = run;
  assign bc_oe   = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; done <= 1'b0; run <= 1'b0; per <= 4'd4;
      cnt <= '0; bitc <= '0;
      bc_clk <= 1'b0; lr_clk <= 1'b0; bit_stb <= 1'b0; frame_stb <= 1'b0;
    end else if (!done) begin
      if (wcnt == WW'(STRAP_CYCLES - 1)) begin
        done      <= 1'b1;
        run       <= master_sel;
        per       <= per_sel;
        cnt       <= '0;
        bitc      <= '0;
        bc_clk    <= 1'b0;
        lr_clk    <= 1'b0;
        bit_stb   <= master_sel;
        frame_stb <= master_sel;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end else if (run) begin
      cnt       <= cnt_n;
      bitc      <= bitc_n;
      bc_clk    <= (cnt_n >= lo);
      lr_clk    <= bitc_n[FW-1];
      bit_stb   <= wrap;
      frame_stb <= wrap && (bitc_n[FW-2:0] == '0);
    end
  end

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_oe |-> (!bc_clk && !lr_clk && !bit_stb && !frame_stb));
  a_r2_enable_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lr_oe) |-> (lr_oe && bc_oe));
  a_r5_lr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_clk != $past(lr_clk)) |-> (!bc_clk && $past(bc_clk)));
  a_r6_bit_stb_low: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> !bc_clk);
  a_r7_frame_in_bit: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> bit_stb);
endmodule

// File: tb/tb_aud_clk_master.sv
module tb_aud_clk_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b1, lr_strap = 1'b0, bc_strap = 1'b0, div_en = 1'b0;
  logic lr_clk, bc_clk, lr_oe, bc_oe, bit_stb, frame_stb;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  aud_clk_master dut (.clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .lr_strap(lr_strap), .bc_strap(bc_strap), .div_en(div_en),
    .lr_clk(lr_clk), .bc_clk(bc_clk), .lr_oe(lr_oe), .bc_oe(bc_oe),
    .bit_stb(bit_stb), .frame_stb(frame_stb));

  // {lr_strap, bc_strap, div_en, expected period[3:0]}
  localparam bit [6:0] VEC [8] = '{
    7'b000_0100, 7'b001_1000, 7'b010_0110, 7'b011_1100,
    7'b100_0010, 7'b101_0100, 7'b110_0011, 7'b111_0110 };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ms, input logic ls, input logic bs, input logic dv);
    @(negedge clk);
    rst_n = 1'b0; master_sel = ms; lr_strap = ls; bc_strap = bs; div_en = dv;
    repeat (3) @(negedge clk);
    chk({lr_clk, bc_clk, lr_oe, bc_oe, bit_stb, frame_stb} == 6'b0, "R9 reset outputs",
        {lr_clk, bc_clk, lr_oe, bc_oe, bit_stb, frame_stb}, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int v = 0; v < 8; v++) begin
      int p, lo, e_bc, e_lr, e_bs, e_fs, first_next;
      p  = int'(VEC[v][3:0]);
      lo = p - p / 2;
      e_bc = 0; e_lr = 0; e_bs = 0; e_fs = 0; first_next = -1;
      do_reset(1'b1, VEC[v][6], VEC[v][5], VEC[v][4]);
      repeat (1023) @(posedge clk);
      @(negedge clk);
      chk(!lr_oe && !bc_oe, "R2 enables low in window", lr_oe, 0);
      @(negedge clk);
      chk(lr_oe && bc_oe, "R2 enables high after window", lr_oe, 1);
      for (int t = 0; t < 2 * 64 * p; t++) begin
        int ph, bi;
        ph = t % p;
        bi = (t / p) % 64;
        if (bc_clk !== (ph >= lo)) e_bc++;
        if (lr_clk !== (bi >= 32)) e_lr++;
        if (bit_stb !== (ph == 0)) e_bs++;
        if (frame_stb !== (ph == 0 && (bi % 32) == 0)) e_fs++;
        if (t > 0 && bit_stb && first_next < 0) first_next = t;
        if (t == 5) begin
          lr_strap = ~lr_strap; bc_strap = ~bc_strap; div_en = ~div_en; master_sel = 1'b0;
        end
        @(negedge clk);
      end
      chk(first_next == p, "R3 period", first_next, p);
      chk(e_bc == 0, "R4 R8 bc_clk pattern errors", e_bc, 0);
      chk(e_lr == 0, "R5 lr_clk pattern errors", e_lr, 0);
      chk(e_bs == 0, "R6 bit_stb errors", e_bs, 0);
      chk(e_fs == 0, "R7 frame_stb errors", e_fs, 0);
    end

    // R1: slave mode stays silent
    begin
      int act;
      act = 0;
      do_reset(1'b0, 1'b1, 1'b1, 1'b0);
      for (int t = 0; t < 1200; t++) begin
        @(negedge clk);
        if (t == 1100) master_sel = 1'b1;
        act |= {lr_oe, bc_oe, lr_clk, bc_clk, bit_stb, frame_stb};
      end
      chk(act == 0, "R1 slave outputs", act, 0);
    end

    // R9: asynchronous reset mid-run
    do_reset(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (1100) @(negedge clk);
    chk(lr_oe == 1'b1, "R2 running before reset", lr_oe, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk({lr_clk, bc_clk, lr_oe, bc_oe, bit_stb, frame_stb} == 6'b0, "R9 async reset",
        {lr_clk, bc_clk, lr_oe, bc_oe, bit_stb, frame_stb}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule